// File: doc/BRIEF.md
# Transmit clock-loss tristate controller

This block decides when a line driver has to be placed in high impedance because its transmit data clock or its reference clock has gone quiet. It runs from its own free-running sampling clock. Each watched clock is brought into that domain through a two-flop synchroniser, and its rising edges are detected there. Silence is measured in nominal bit periods. A programmable divider of the sampling clock produces one tick per bit period.

The silence limit depends on the transmit path. With the jitter attenuator in the path the limit is long (176 bit periods). With the attenuator bypassed it is short (8 bit periods). After a forced tristate, the driver comes back only once four fresh transmit clock edges have been counted. In host mode it also waits for a write to the 4-bit configuration field, and a status bit reports the clock-lost tristate. When remote loopback is selected, a missing transmit clock does not force tristate. A separate settling flag is raised for 22 bit periods whenever the configuration field, the all-ones control or the local loopback control changes.

Top module: `txcl_tristate_ctrl`

## Requirements
- R1: With `jitter_path_i` low, once no rising edge of `tx_clk_i` has been detected for 8 bit periods (one bit period is BIT_DIV = 4 sampling cycles), `drv_en_o` falls to 0. The delay is at most 9 bit periods plus three sampling cycles after the last edge, and `drv_en_o` stays 1 while edges keep arriving every two bit periods or sooner.
- R2: With `jitter_path_i` high, the same silence limit is 176 bit periods instead of 8.
- R3: A silent `ref_clk_i` forces `drv_en_o` to 0 under the same limit that applies to the transmit clock.
- R4: While tristated, the block counts rising edges of `tx_clk_i`. When four have been seen and neither clock is timed out, `drv_en_o` returns to 1 (in hardware mode). Any new timeout before that point restarts the count from zero.
- R5: From reset, `drv_en_o` is 0 and stays 0 until `ref_clk_i` is active and four `tx_clk_i` rising edges have arrived.
- R6: In host mode (`host_mode_i` = 1), `clk_lost_o` is 1 for as long as the driver is held in tristate.
- R7: In host mode, the driver does not re-enable by itself when the clocks return. It re-enables only after a pulse on `cfg_wr_i` during the tristate and four edges on valid clocks.
- R8: While `rmt_loop_i` is 1, a silent `tx_clk_i` never drives `drv_en_o` from 1 to 0. A silent reference clock still does.
- R9: A change of the stored configuration field, of `all_ones_i` or of `local_loop_i` raises `settling_o` within three sampling cycles. The flag stays high for 22 bit periods: it is still 1 80 cycles after the change and 0 after 100 cycles. A write of an unchanged value does not raise it.
- R10: In hardware mode (`host_mode_i` = 0), `clk_lost_o` stays 0, including during a forced tristate. At reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_clk_i | input | 1 | Monitored transmit data clock (asynchronous) |
| ref_clk_i | input | 1 | Monitored reference clock (asynchronous) |
| jitter_path_i | input | 1 | 1: jitter attenuator in transmit path (long limit) |
| rmt_loop_i | input | 1 | 1: remote loopback selected |
| host_mode_i | input | 1 | 1: host mode, 0: hardware mode |
| cfg_wr_i | input | 1 | One-cycle strobe writing `cfg_i` into the configuration field |
| cfg_i | input | 4 | Configuration field value |
| all_ones_i | input | 1 | All-ones transmit control |
| local_loop_i | input | 1 | Local loopback control |
| drv_en_o | output | 1 | Driver enable; 0 means the driver is tristated |
| clk_lost_o | output | 1 | Host-mode clock-lost status |
| settling_o | output | 1 | Transmitter settling window after a configuration change |

## Verification
An inactivity counter stuck or miscounted shows up within one timeout window. `drv_en_o` falls either too early, while edges are still arriving, or never, after the limit for the selected path has passed. A wrong recovery edge count or a restart that fails to clear it shows within one pulse of the expected re-enable, with `drv_en_o` rising one edge early or late. A lost host-write flag shows at once: the driver re-enables without the write, or not after it. A bad settling counter shows at the 80- and 100-cycle sample points that follow any control change.

// File: rtl/txcl_pkg.sv
package txcl_pkg;
  typedef enum logic {
    DRV_OFF = 1'b0,
    DRV_ON  = 1'b1
  } drv_state_e;

  localparam int unsigned MON_TX  = 0;
  localparam int unsigned MON_REF = 1;
  localparam int unsigned MON_NUM = 2;
endpackage

// File: rtl/txcl_bit_tick.sv
module txcl_bit_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      // R1: bit-period ticks are isolated pulses
      p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/txcl_clk_mon.sv
module txcl_clk_mon #(
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mon_clk_i,
  input  logic              tick_i,
  input  logic [IDLE_W-1:0] thr_i,
  output logic              edge_o,
  output logic              timeout_o
);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [1:0]        sync_q;
  logic              last_q;
  logic [IDLE_W-1:0] idle_q, idle_d;

  always_comb begin
    edge_o = sync_q[1] & ~last_q;
    idle_d = idle_q;
    if (edge_o)
      idle_d = '0;
    else if (tick_i && (idle_q != IDLE_MAX))
      idle_d = idle_q + 1'b1;
    timeout_o = (idle_q >= thr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      last_q <= 1'b1;
      idle_q <= IDLE_MAX;
    end else begin
      sync_q <= {sync_q[0], mon_clk_i};
      last_q <= sync_q[1];
      idle_q <= idle_d;
    end
  end

  // R1: a detected edge restarts the silence measurement
  p_edge_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (idle_q == '0));
  // R2: the silence counter saturates instead of wrapping
  p_idle_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idle_q == IDLE_MAX) && !edge_o) |=> (idle_q == IDLE_MAX));
endmodule

// File: rtl/txcl_settle.sv
module txcl_settle #(
  parameter int unsigned SETTLE_BITS = 22,
  parameter int unsigned WATCH_W     = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [WATCH_W-1:0] watch_i,
  output logic               busy_o
);
  localparam int unsigned SW = $clog2(SETTLE_BITS + 1);
  localparam logic [SW-1:0] LOAD = SW'(SETTLE_BITS);

  logic [WATCH_W-1:0] prev_q;
  logic [SW-1:0]      cnt_q, cnt_d;
  logic               changed;

  always_comb begin
    changed = (watch_i != prev_q);
    cnt_d   = cnt_q;
    if (changed)
      cnt_d = LOAD;
    else if (tick_i && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
    busy_o = (cnt_q != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= watch_i;
      cnt_q  <= cnt_d;
    end
  end

  // R9: the settling window never exceeds its length
  p_settle_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
  // R9: without a new change the window only shrinks
  p_settle_shrinks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q != '0) && !changed) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/txcl_tristate_ctrl.sv
module txcl_tristate_ctrl
  import txcl_pkg::*;
#(
  parameter int unsigned BIT_DIV       = 4,
  parameter int unsigned THR_SHORT     = 8,
  parameter int unsigned THR_LONG      = 176,
  parameter int unsigned SETTLE_BITS   = 22,
  parameter int unsigned CFG_W         = 4,
  parameter int unsigned RECOVER_EDGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_clk_i,
  input  logic             ref_clk_i,
  input  logic             jitter_path_i,
  input  logic             rmt_loop_i,
  input  logic             host_mode_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             all_ones_i,
  input  logic             local_loop_i,
  output logic             drv_en_o,
  output logic             clk_lost_o,
  output logic             settling_o
);
  localparam int unsigned THR_MAX = (THR_LONG > THR_SHORT) ? THR_LONG : THR_SHORT;
  localparam int unsigned IDLE_W  = $clog2(THR_MAX + 1);
  localparam int unsigned EDGE_W  = $clog2(RECOVER_EDGES + 1);
  localparam logic [EDGE_W-1:0] EDGE_DONE = EDGE_W'(RECOVER_EDGES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // bit-period tick
  logic tick;
  txcl_bit_tick #(.DIV(BIT_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_o (tick)
  );

  // clock activity monitors
  logic [IDLE_W-1:0]  thr;
  logic [MON_NUM-1:0] mon_clk, mon_edge, mon_to;

  assign thr     = jitter_path_i ? IDLE_W'(THR_LONG) : IDLE_W'(THR_SHORT);
  assign mon_clk = {ref_clk_i, tx_clk_i};

  generate
    for (genvar g = 0; g < MON_NUM; g++) begin : g_mon
      txcl_clk_mon #(.IDLE_W(IDLE_W)) u_mon (
        .clk_i     (clk_i),
        .rst_ni    (rst_n_int),
        .mon_clk_i (mon_clk[g]),
        .tick_i    (tick),
        .thr_i     (thr),
        .edge_o    (mon_edge[g]),
        .timeout_o (mon_to[g])
      );
    end
  endgenerate

  // configuration field and settling window
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  txcl_settle #(.SETTLE_BITS(SETTLE_BITS), .WATCH_W(CFG_W + 2)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .tick_i  (tick),
    .watch_i ({cfg_q, all_ones_i, local_loop_i}),
    .busy_o  (settling_o)
  );

  // tristate control
  drv_state_e        state_q, state_d;
  logic [EDGE_W-1:0] edges_q, edges_d;
  logic              wr_q, wr_d;
  logic              force_q, force_off, fresh_to;

  always_comb begin
    force_off = (mon_to[MON_TX] & ~rmt_loop_i) | mon_to[MON_REF];
    fresh_to  = force_off & ~force_q;
    state_d   = state_q;
    edges_d   = edges_q;
    wr_d      = wr_q;
    unique case (state_q)
      DRV_ON: begin
        if (force_off) begin
          state_d = DRV_OFF;
          edges_d = '0;
          wr_d    = 1'b0;
        end
      end
      default: begin
        if (fresh_to)
          edges_d = '0;
        else if (mon_edge[MON_TX] && (edges_q != EDGE_DONE))
          edges_d = edges_q + 1'b1;
        if (cfg_wr_i) wr_d = 1'b1;
        if (!force_off && (edges_q == EDGE_DONE) && (!host_mode_i || wr_q))
          state_d = DRV_ON;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= DRV_OFF;
      edges_q <= '0;
      wr_q    <= 1'b0;
      force_q <= 1'b1;
    end else begin
      state_q <= state_d;
      edges_q <= edges_d;
      wr_q    <= wr_d;
      force_q <= force_off;
    end
  end

  assign drv_en_o   = (state_q == DRV_ON);
  assign clk_lost_o = host_mode_i & (state_q == DRV_OFF);

  // R3: any monitor timeout outside remote loopback drops the driver
  p_force_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (drv_en_o && force_off) |=> !drv_en_o);
  // R3: a reference edge clears its timeout on the next cycle
  p_ref_edge_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    mon_edge[MON_REF] |=> !mon_to[MON_REF]);
  // R8: remote loopback keeps the driver up while the reference is alive
  p_rloop_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (drv_en_o && rmt_loop_i && !mon_to[MON_REF]) |=> drv_en_o);
  // R4: enable only follows a full set of recovery edges
  p_enable_edges_r4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $rose(drv_en_o) |-> ($past(edges_q) == EDGE_DONE));
  // R4: recovery edge count never passes its target
  p_edges_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    edges_q <= EDGE_DONE);
  // R7: host-mode enable requires a configuration write during tristate
  p_host_write_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($rose(drv_en_o) && $past(host_mode_i)) |-> $past(wr_q));
endmodule

// File: tb/txcl_tristate_ctrl_tb_top.sv
module txcl_tristate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // row fields: [6] jitter [5] rloop [4] host [3] kill tx [2] kill ref
  //             [1] expected enable late [0] expected clk_lost late
  localparam logic [6:0] ROWS [9] = '{
    7'b0001000, 7'b1001000, 7'b0000100, 7'b1000100, 7'b0101010,
    7'b0100100, 7'b0011001, 7'b1010101, 7'b1101010
  };

  logic clk, rst_n;
  logic tx_gen, tx_man, ref_gen, tx_run, ref_run;
  logic jit, rloop, host, cfg_wr, all_ones, lloop;
  logic [3:0] cfg;
  logic drv_en, clk_lost, settling;
  int   n_cmp, n_bad;
  logic done;

  txcl_tristate_ctrl dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tx_clk_i      (tx_gen | tx_man),
    .ref_clk_i     (ref_gen),
    .jitter_path_i (jit),
    .rmt_loop_i    (rloop),
    .host_mode_i   (host),
    .cfg_wr_i      (cfg_wr),
    .cfg_i         (cfg),
    .all_ones_i    (all_ones),
    .local_loop_i  (lloop),
    .drv_en_o      (drv_en),
    .clk_lost_o    (clk_lost),
    .settling_o    (settling)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    tx_gen = 1'b0;
    forever begin
      if (tx_run) begin
        tx_gen = 1'b1; #(4 * CLK_PERIOD);
        tx_gen = 1'b0; #(4 * CLK_PERIOD);
      end else begin
        tx_gen = 1'b0; #(CLK_PERIOD);
      end
    end
  end

  initial begin
    ref_gen = 1'b0;
    forever begin
      if (ref_run) begin
        ref_gen = 1'b1; #(3 * CLK_PERIOD);
        ref_gen = 1'b0; #(3 * CLK_PERIOD);
      end else begin
        ref_gen = 1'b0; #(CLK_PERIOD);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] v);
    cfg    = v;
    cfg_wr = 1'b1;
    wait_cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic tx_pulse();
    tx_man = 1'b1; wait_cyc(3);
    tx_man = 1'b0; wait_cyc(5);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    done = 1'b0; n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; tx_run = 1'b0; ref_run = 1'b0; tx_man = 1'b0;
    jit = 1'b0; rloop = 1'b0; host = 1'b0; cfg_wr = 1'b0; cfg = 4'h0;
    all_ones = 1'b0; lloop = 1'b0;

    // reset state (R10) and start-up hold (R5)
    wait_cyc(5);
    check("R10 reset drv_en", drv_en, 1'b0);
    check("R10 reset clk_lost", clk_lost, 1'b0);
    check("R10 reset settling", settling, 1'b0);
    rst_n = 1'b1;
    wait_cyc(200);
    check("R5 no clocks", drv_en, 1'b0);
    ref_run = 1'b1;
    wait_cyc(200);
    check("R5 ref only", drv_en, 1'b0);
    for (int k = 0; k < 3; k++) tx_pulse();
    check("R5 three edges", drv_en, 1'b0);
    tx_pulse();
    check("R5 fourth edge", drv_en, 1'b1);

    // timeout and recovery-count restart (R1, R4)
    wait_cyc(60);
    check("R1 tx silent short path", drv_en, 1'b0);
    for (int k = 0; k < 3; k++) tx_pulse();
    wait_cyc(60);
    for (int k = 0; k < 3; k++) tx_pulse();
    check("R4 count restarted", drv_en, 1'b0);
    tx_pulse();
    check("R4 recovered", drv_en, 1'b1);

    // table of mode / clock-loss vectors
    for (int i = 0; i < 9; i++) begin
      logic [6:0] r;
      string tag;
      r = ROWS[i];
      jit = r[6]; rloop = r[5]; host = r[4];
      tag = r[3] ? (r[5] ? "R8" : (r[6] ? "R2" : "R1")) : "R3";
      tx_run = 1'b1; ref_run = 1'b1;
      wait_cyc(100);
      if (host) host_write(4'(i));
      wait_cyc(20);
      check("R4 row start enabled", drv_en, 1'b1);
      if (r[3]) tx_run = 1'b0;
      if (r[2]) ref_run = 1'b0;
      wait_cyc(r[6] ? 500 : 12);
      check({tag, " early"}, drv_en, 1'b1);
      wait_cyc(r[6] ? 400 : 60);
      check({tag, " late"}, drv_en, r[1]);
      check(host ? "R6 lost late" : "R10 lost late", clk_lost, r[0]);
      tx_run = 1'b1; ref_run = 1'b1;
      wait_cyc(100);
      if (host) begin
        check("R7 no self enable", drv_en, 1'b0);
        check("R6 lost held", clk_lost, 1'b1);
        host_write(4'(i + 1));
        wait_cyc(20);
        check("R7 enable after write", drv_en, 1'b1);
      end else begin
        check("R4 restored", drv_en, 1'b1);
      end
    end
    host = 1'b0; rloop = 1'b0; jit = 1'b0;

    // settling window (R9)
    wait_cyc(200);
    check("R9 idle", settling, 1'b0);
    all_ones = 1'b1;
    wait_cyc(3);
    check("R9 all-ones rise", settling, 1'b1);
    wait_cyc(77);
    check("R9 held 80", settling, 1'b1);
    wait_cyc(20);
    check("R9 ended 100", settling, 1'b0);
    lloop = 1'b1;
    wait_cyc(3);
    check("R9 local loop", settling, 1'b1);
    wait_cyc(100);
    host_write(4'hA);
    wait_cyc(3);
    check("R9 cfg change", settling, 1'b1);
    wait_cyc(100);
    check("R9 cfg ended", settling, 1'b0);
    host_write(4'hA);
    wait_cyc(3);
    check("R9 same value", settling, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule